// File: doc/BRIEF.md
# Nine-bit Multidrop Address Detector

This block sits on the receive path of an asynchronous serial port, between the character deframer and the receive FIFO. Each deframed character arrives as a 9-bit word with a one-cycle valid strobe. When nine-bit framing is on, the top bit of the word tells an address character (top bit 1) from a data character (top bit 0). The whole 9-bit word goes to the FIFO together with an address flag. When nine-bit framing is off, the word is cut down to the configured 5 to 8 data bits.

An address character can raise a special-character interrupt in one of two ways. In the first, every address character raises it. In the second, the address character must equal one of four programmable 9-bit match values, and each of those values has its own enable. The interrupt does not fire when the character is recognised. It fires when the character is actually written into the FIFO. A character that arrives while the FIFO reports full is dropped and raises nothing. The pending bit stays set until a status read clears it. The interrupt line is the pending bit gated by an enable.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After a synchronous active-low reset, `fifo_push`, `irq_pend` and `irq` are 0.
- R2: When `nine_en`=1, a strobed character with `fifo_full`=0 appears one cycle later on `fifo_data` as all 9 bits, with `fifo_push`=1 and `addr_flag` equal to bit 8 of the character.
- R3: When `nine_en`=1, the `data_len` setting has no effect on `fifo_data`.
- R4: When `nine_en`=0, `fifo_data` keeps only the low 5+`data_len` bits, where `data_len` 0..3 selects 5..8 bits. All higher bits are 0, and `addr_flag` is 0. Such a character never sets `irq_pend`.
- R5: A character strobed while `fifo_full`=1 produces no `fifo_push` and never sets `irq_pend`.
- R6: With `cmp_mode`=0, every pushed address character sets `irq_pend`. The bit is set on the clock edge at which the FIFO captures the character, so it is visible two cycles after the strobe.
- R7: With `cmp_mode`=1, a pushed address character sets `irq_pend` only if all 9 of its bits equal an enabled match value. Match value i is `match_vals[9*i+8:9*i]`.
- R8: A match value whose bit in `cmp_en` is 0 never causes a match.
- R9: A data character (bit 8 = 0) never sets `irq_pend`, even when it equals an enabled match value.
- R10: A `stat_rd` pulse clears `irq_pend` one cycle later. If a new set falls on the same edge as the read, the set wins and `irq_pend` stays 1.
- R11: `irq` equals `irq_pend` AND `irq_en`. `irq_pend` latches whatever the value of `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chr_vld | input | 1 | One-cycle strobe for a deframed character |
| chr_bits | input | 9 | Deframed character; bit 8 is the ninth bit |
| fifo_full | input | 1 | FIFO cannot take a character this cycle |
| nine_en | input | 1 | Nine-bit framing enable |
| data_len | input | 2 | Normal-mode data length: 0..3 selects 5..8 bits |
| cmp_mode | input | 1 | 0: any address char interrupts; 1: only matching ones |
| cmp_en | input | 4 | Per-match-value enable |
| match_vals | input | 36 | Four 9-bit match values, value i at bits 9*i+8:9*i |
| irq_en | input | 1 | Interrupt line enable |
| stat_rd | input | 1 | Status read pulse; clears the pending bit |
| fifo_push | output | 1 | Write strobe into the receive FIFO |
| fifo_data | output | 9 | Character written into the FIFO |
| addr_flag | output | 1 | Pushed character is an address character |
| irq_pend | output | 1 | Special-character interrupt pending |
| irq | output | 1 | Gated interrupt request |

## Verification
A status read and a new match can land on the same clock edge. This happens when software reads status just as a second address character is written into the FIFO. The bench provokes it by raising `stat_rd` in the cycle where `fifo_push` is high for a matching character. It then judges the outcome by requiring `irq_pend` to still read 1 in the following cycle, so the read must not swallow the new event. A second read afterwards must return the bit to 0.

// File: rtl/mdrop_pkg.sv
// Shared definitions for the nine-bit multidrop address detector.
// Assumes characters are at most nine bits wide, ninth bit on top.
package mdrop_pkg;

    localparam int CHR_W   = 9;
    localparam int LEN_W   = 2;
    localparam int MIN_LEN = 5;

    typedef logic [CHR_W-1:0] chr_t;

    // One classified character as handed to the output stage.
    typedef struct packed {
        logic  push;
        chr_t  data;
        logic  addr;
        logic  hit;
    } cls_t;

    // Mask keeping the low MIN_LEN+len bits of a character.
    function automatic chr_t len_mask(input logic [LEN_W-1:0] len);
        logic [CHR_W:0] t;
        t = ({{CHR_W{1'b0}}, 1'b1} << (MIN_LEN + int'(len))) - 1'b1;
        return t[CHR_W-1:0];
    endfunction

endpackage

// File: rtl/mdrop_classify.sv
// Combinational classifier: masks the character for the framing mode,
// flags address characters and decides whether the character would
// raise the special-character interrupt once written to the FIFO.
// Assumes chr_vld is a single-cycle strobe from the deframer.
module mdrop_classify
    import mdrop_pkg::*;
#(
    parameter int NUM_CMP = 4
) (
    input  logic                     chr_vld,
    input  chr_t                     chr_bits,
    input  logic                     fifo_full,
    input  logic                     nine_en,
    input  logic [LEN_W-1:0]         data_len,
    input  logic                     cmp_mode,
    input  logic [NUM_CMP-1:0]       cmp_en,
    input  logic [NUM_CMP*CHR_W-1:0] match_vals,
    output cls_t                     cls
);

    logic [NUM_CMP-1:0] cmp_hit;
    logic               is_addr;
    logic               any_hit;

    // Address characters exist only in nine-bit framing.
    assign is_addr = nine_en & chr_bits[CHR_W-1];

    // One full-width comparator per match value, each with its own enable.
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        assign cmp_hit[i] = cmp_en[i] &
                            (chr_bits == match_vals[i*CHR_W +: CHR_W]);
    end

    assign any_hit = |cmp_hit;

    // Build the outgoing record: data mask, address flag, interrupt hit.
    always_comb begin
        cls.push = chr_vld & ~fifo_full;
        cls.data = nine_en ? chr_bits : (chr_bits & len_mask(data_len));
        cls.addr = is_addr;
        cls.hit  = is_addr & (cmp_mode ? any_hit : 1'b1);
    end

endmodule

// File: rtl/mdrop_stage.sv
// Output register stage: holds the character presented to the FIFO
// and the hit decision that travels with it.
// Assumes the FIFO writes on the edge at which fifo_push is high.
module mdrop_stage
    import mdrop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chr_vld,
    input  logic fifo_full,
    input  cls_t cls,
    output logic fifo_push,
    output chr_t fifo_data,
    output logic addr_flag,
    output logic hit_q
);

    // Register the classified character; data is held when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_push <= 1'b0;
            fifo_data <= '0;
            addr_flag <= 1'b0;
            hit_q     <= 1'b0;
        end else begin
            fifo_push <= cls.push;
            hit_q     <= cls.push & cls.hit;
            if (cls.push) begin
                fifo_data <= cls.data;
                addr_flag <= cls.addr;
            end
        end
    end

    a_r5_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && fifo_full) |=> !fifo_push);

    a_r2_push_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && !fifo_full) |=> fifo_push);

    a_r2_addr_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && addr_flag) |-> fifo_data[CHR_W-1]);

endmodule

// File: rtl/mdrop_irq.sv
// Pending-interrupt holder: sets on a FIFO write of a hit character,
// clears on a status read, set taking priority on the same edge.
// Assumes stat_rd is a single-cycle pulse.
module mdrop_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic stat_rd,
    input  logic irq_en,
    output logic irq_pend,
    output logic irq
);

    // Pending bit with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_pend <= 1'b0;
        else if (set_req) irq_pend <= 1'b1;
        else if (stat_rd) irq_pend <= 1'b0;
    end

    // Interrupt line gated by its enable.
    assign irq = irq_pend & irq_en;

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> irq_pend);

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !set_req) |=> !irq_pend);

    a_r11_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !stat_rd) |=> irq_pend);

endmodule

// File: rtl/mdrop_addr_filter.sv
// Top of the nine-bit multidrop address detector. Classifies each
// deframed character, hands it to the receive FIFO one cycle later and
// raises the special-character interrupt as the FIFO captures it.
// Assumes the deframer supplies at most one character per cycle.
module mdrop_addr_filter
    import mdrop_pkg::*;
#(
    parameter int NUM_CMP = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chr_vld,
    input  logic [CHR_W-1:0]         chr_bits,
    input  logic                     fifo_full,
    input  logic                     nine_en,
    input  logic [LEN_W-1:0]         data_len,
    input  logic                     cmp_mode,
    input  logic [NUM_CMP-1:0]       cmp_en,
    input  logic [NUM_CMP*CHR_W-1:0] match_vals,
    input  logic                     irq_en,
    input  logic                     stat_rd,
    output logic                     fifo_push,
    output logic [CHR_W-1:0]         fifo_data,
    output logic                     addr_flag,
    output logic                     irq_pend,
    output logic                     irq
);

    cls_t cls;
    logic hit_q;
    logic set_req;

    mdrop_classify #(.NUM_CMP(NUM_CMP)) u_cls (
        .chr_vld    (chr_vld),
        .chr_bits   (chr_bits),
        .fifo_full  (fifo_full),
        .nine_en    (nine_en),
        .data_len   (data_len),
        .cmp_mode   (cmp_mode),
        .cmp_en     (cmp_en),
        .match_vals (match_vals),
        .cls        (cls)
    );

    mdrop_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .chr_vld   (chr_vld),
        .fifo_full (fifo_full),
        .cls       (cls),
        .fifo_push (fifo_push),
        .fifo_data (fifo_data),
        .addr_flag (addr_flag),
        .hit_q     (hit_q)
    );

    // Interrupt sets on the FIFO write of a hit character.
    assign set_req = fifo_push & hit_q;

    mdrop_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (set_req),
        .stat_rd  (stat_rd),
        .irq_en   (irq_en),
        .irq_pend (irq_pend),
        .irq      (irq)
    );

    a_r9_data_never_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && !addr_flag) |=> !$rose(irq_pend));

    a_r4_normal_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && !fifo_full && !nine_en) |=> !addr_flag);

    a_r1_no_push_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !chr_vld |=> !fifo_push);

endmodule

// File: tb/mdrop_addr_filter_test.sv
`timescale 1ns/1ps
module mdrop_addr_filter_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        chr_vld, fifo_full, nine_en, cmp_mode, irq_en, stat_rd;
    logic [8:0]  chr_bits;
    logic [1:0]  data_len;
    logic [3:0]  cmp_en;
    logic [35:0] match_vals;
    logic        fifo_push, addr_flag, irq_pend, irq;
    logic [8:0]  fifo_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct packed { logic [8:0] data; logic addr; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    mdrop_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_bits(chr_bits),
        .fifo_full(fifo_full), .nine_en(nine_en), .data_len(data_len),
        .cmp_mode(cmp_mode), .cmp_en(cmp_en), .match_vals(match_vals),
        .irq_en(irq_en), .stat_rd(stat_rd), .fifo_push(fifo_push),
        .fifo_data(fifo_data), .addr_flag(addr_flag),
        .irq_pend(irq_pend), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Expected FIFO word from the requirements (R2, R3, R4).
    function automatic exp_t model(input logic [8:0] c);
        exp_t e;
        logic [8:0] m;
        m = 9'((10'd1 << (5 + int'(data_len))) - 10'd1);
        e.data = nine_en ? c : (c & m);
        e.addr = nine_en & c[8];
        return e;
    endfunction

    // Monitor: every FIFO write is popped and compared.
    always @(negedge clk) begin
        if (rst_n && fifo_push) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected push", int'(fifo_data), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(fifo_data == e.data, "R2/R3/R4 data", int'(fifo_data), int'(e.data));
                chk(addr_flag == e.addr, "R2/R4 addr_flag", int'(addr_flag), int'(e.addr));
            end
        end
    end

    // Driver: one character, then pending check, then a clearing read.
    task automatic send(input logic [8:0] c, input bit full, input bit exp_pend,
                        input bit rd_same, input string req);
        @(negedge clk);
        chr_vld = 1'b1; chr_bits = c; fifo_full = full;
        if (!full) exp_q.push_back(model(c));
        @(negedge clk);
        chr_vld = 1'b0; fifo_full = 1'b0; stat_rd = rd_same;
        if (full) chk(fifo_push == 1'b0, "R5 push while full", int'(fifo_push), 0);
        @(negedge clk);
        stat_rd = 1'b0;
        chk(irq_pend == exp_pend, req, int'(irq_pend), int'(exp_pend));
        chk(irq == (exp_pend & irq_en), "R11 irq gate", int'(irq), int'(exp_pend & irq_en));
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk(irq_pend == 1'b0, "R10 read clears", int'(irq_pend), 0);
    endtask

    initial begin
        rst_n = 1'b0; chr_vld = 0; chr_bits = '0; fifo_full = 0; nine_en = 1;
        data_len = 2'd3; cmp_mode = 0; cmp_en = '0; match_vals = '0;
        irq_en = 1; stat_rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(fifo_push == 0, "R1 push", int'(fifo_push), 0);
        chk(irq_pend == 0, "R1 pend", int'(irq_pend), 0);
        chk(irq == 0, "R1 irq", int'(irq), 0);

        // R2 / R6: any address character interrupts
        send(9'h1A5, 0, 1, 0, "R6 address sets pending");
        // R9 data char in any-address mode
        send(9'h0A5, 0, 0, 0, "R9 data char no irq");
        // R3: length setting ignored in nine-bit mode
        data_len = 2'd0;
        send(9'h1FF, 0, 1, 0, "R3 len ignored");
        // R4: normal mode truncation, no interrupt
        nine_en = 0;
        send(9'h1FF, 0, 0, 0, "R4 5-bit no irq");
        data_len = 2'd2;
        send(9'h0C3, 0, 0, 0, "R4 7-bit");
        data_len = 2'd3;
        send(9'h1C3, 0, 0, 0, "R4 8-bit top bit ignored");
        nine_en = 1;
        // R5: full FIFO drops the character
        send(9'h155, 1, 0, 0, "R5 dropped no irq");

        // R7 / R8 / R9 match mode
        cmp_mode = 1;
        match_vals = {9'h1CC, 9'h0AA, 9'h1F0, 9'h101};
        cmp_en = 4'b0111;
        send(9'h1F0, 0, 1, 0, "R7 match value 1");
        send(9'h101, 0, 1, 0, "R7 match value 0");
        send(9'h102, 0, 0, 0, "R7 near miss");
        send(9'h1CC, 0, 0, 0, "R8 disabled comparator");
        send(9'h0AA, 0, 0, 0, "R9 data equals match value");
        cmp_en = 4'b1111;
        send(9'h1CC, 0, 1, 0, "R8 enabled comparator");

        // R11: pending latches with line disabled
        irq_en = 0;
        send(9'h101, 0, 1, 0, "R11 pend with irq_en low");

        // R10: read on the same edge as a new set
        irq_en = 1;
        send(9'h1F0, 0, 1, 1, "R10 set wins over read");

        // Back-to-back characters keep order (R2)
        cmp_mode = 0;
        @(negedge clk);
        chr_vld = 1; chr_bits = 9'h033; exp_q.push_back(model(9'h033));
        @(negedge clk);
        chr_bits = 9'h1E1; exp_q.push_back(model(9'h1E1));
        @(negedge clk);
        chr_vld = 0;
        @(negedge clk);
        chr_vld = 0;
        chk(irq_pend == 1, "R6 second of pair", int'(irq_pend), 1);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all pushes seen", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule